// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Checker

This block watches the stream of retired instructions, at most one per clock, and checks that every indirect jump or indirect call lands on a marked target. Each retired instruction carries a two-bit class tag. When an indirect transfer retires, the checker arms. The next retired instruction must then be the landing-pad marker. If it is anything else, the checker raises a one-cycle control-protection fault.

The armed flag is part of the thread's saved context. When an exception or context switch is taken, the surrounding logic samples `pend_out`, stores it, and pulses `ctx_save`. This disarms the checker so that the handler runs unchecked. On return, `ctx_restore` together with `restore_pend` loads the flag back. An exception taken between a branch and its target therefore cannot skip the check: the first instruction retired after the return is checked.

The state machine has two states:
- IDLE: nothing is pending.
- WAIT: a landing pad is expected.

Its transitions are:
- ARM: IDLE to WAIT, when an indirect jump or call retires.
- LAND: WAIT to IDLE, when the marker retires.
- VIOLATE: WAIT to IDLE, when any other instruction retires. This transition also raises the fault.
- STASH: to IDLE, on `ctx_save`.
- RELOAD: to WAIT or IDLE, on `ctx_restore`, following `restore_pend`.
- HOLD: no change, when the cycle has no retire and no context event.
- OFF: to IDLE, whenever `chk_en` is low.

Top module: `landing_pad_guard`

## Requirements
- R1: After reset, and whenever `rst_n` is low, the checker is in IDLE, `pend_out` is 0 and `cp_fault` is 0.
- R2: With `chk_en` high and `ret_valid` high, a retired class of 2'b01 (indirect jump) or 2'b10 (indirect call) in IDLE makes `pend_out` 1 from the next cycle.
- R3: A retired class of 2'b00 (other instruction, including direct branches and returns) never arms the checker.
- R4: In WAIT, a retired class of 2'b11 (landing-pad marker) returns the checker to IDLE with no fault.
- R5: In WAIT, a retired class other than 2'b11, an indirect transfer included, sets `cp_fault` for exactly one cycle, the cycle after that retire. On the same edge the checker returns to IDLE.
- R6: A marker retired in IDLE has no effect: no fault, and the checker stays in IDLE.
- R7: A cycle with `ret_valid` low and no context event leaves the state unchanged, whatever the class tag carries.
- R8: `pend_out` shows the armed flag in the cycle that `ctx_save` is asserted. `ctx_save` moves the checker to IDLE, and any retire in that cycle is ignored.
- R9: `ctx_restore` loads the state from `restore_pend`: 1 gives WAIT, 0 gives IDLE. It has priority over `ctx_save` and over a retire in the same cycle.
- R10: With `chk_en` low, the checker goes to IDLE and raises no fault. Retires and restores are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Enables the check |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_class | input | 2 | Class tag: 00 other, 01 indirect jump, 10 indirect call, 11 landing-pad marker |
| ctx_save | input | 1 | An exception or context switch is taken; disarms the checker |
| ctx_restore | input | 1 | Returning to the thread; loads `restore_pend` |
| restore_pend | input | 1 | Saved armed flag being restored |
| pend_out | output | 1 | Armed flag (1 in WAIT), exported for saving |
| cp_fault | output | 1 | One-cycle control-protection fault |

## Verification
A wrong internal state shows up at the ports within one edge, because `pend_out` comes straight from the state register and the fault is registered from it. A checker that wrongly stays armed faults on the next ordinary instruction. A checker that wrongly disarms lets a bad target through silently, and only `pend_out` can reveal that, in the cycle after the offending retire. The stimulus therefore pairs every context event with a following retire, so that the fault or its absence shows whether the saved flag was honoured.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER  = 2'b00,
        CLS_IJMP   = 2'b01,
        CLS_ICALL  = 2'b10,
        CLS_MARKER = 2'b11
    } ret_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } guard_state_e;
endpackage

// File: rtl/lpg_classify.sv
module lpg_classify
    import lpg_pkg::*;
(
    input  logic             ret_valid,
    input  logic [CLS_W-1:0] ret_class,
    output logic             arm_ev,
    output logic             pad_ev,
    output logic             bad_ev
);
    always_comb begin
        arm_ev = 1'b0;
        pad_ev = 1'b0;
        bad_ev = 1'b0;
        if (ret_valid) begin
            unique case (ret_class)
                CLS_IJMP, CLS_ICALL: begin
                    arm_ev = 1'b1;
                    bad_ev = 1'b1;
                end
                CLS_MARKER: pad_ev = 1'b1;
                default:    bad_ev = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/lpg_fsm.sv
module lpg_fsm
    import lpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_en,
    input  logic arm_ev,
    input  logic pad_ev,
    input  logic bad_ev,
    input  logic ctx_save,
    input  logic ctx_restore,
    input  logic restore_pend,
    output logic pend_out,
    output logic cp_fault
);
    guard_state_e state_q, state_d;
    logic         fault_d;

    // next state and fault decision
    always_comb begin
        state_d = state_q;
        fault_d = 1'b0;
        if (!chk_en) begin
            state_d = ST_IDLE;                       // OFF
        end else if (ctx_restore) begin
            state_d = restore_pend ? ST_WAIT : ST_IDLE; // RELOAD
        end else if (ctx_save) begin
            state_d = ST_IDLE;                       // STASH
        end else begin
            unique case (state_q)
                ST_IDLE: if (arm_ev) state_d = ST_WAIT;   // ARM
                ST_WAIT: begin
                    if (pad_ev) begin
                        state_d = ST_IDLE;           // LAND
                    end else if (bad_ev) begin
                        state_d = ST_IDLE;           // VIOLATE
                        fault_d = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) cp_fault <= 1'b0;
        else        cp_fault <= fault_d;
    end

    assign pend_out = (state_q == ST_WAIT);

    // R5
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_fault |=> !cp_fault);
    // R5
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_fault) |-> ($past(pend_out) && $past(chk_en) && !$past(pad_ev)
                             && !$past(ctx_save) && !$past(ctx_restore) && !pend_out));
    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> (!pend_out && !cp_fault));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !arm_ev && !pad_ev && !bad_ev && !ctx_save && !ctx_restore)
        |=> ($stable(pend_out) && !cp_fault));
    // R6
    idle_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_out && !ctx_restore) |=> !cp_fault);
    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && ctx_restore) |=> (pend_out == $past(restore_pend)));
endmodule

// File: rtl/landing_pad_guard.sv
module landing_pad_guard
    import lpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             ret_valid,
    input  logic [CLS_W-1:0] ret_class,
    input  logic             ctx_save,
    input  logic             ctx_restore,
    input  logic             restore_pend,
    output logic             pend_out,
    output logic             cp_fault
);
    logic arm_ev, pad_ev, bad_ev;

    lpg_classify u_cls (
        .ret_valid (ret_valid),
        .ret_class (ret_class),
        .arm_ev    (arm_ev),
        .pad_ev    (pad_ev),
        .bad_ev    (bad_ev)
    );

    lpg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_en       (chk_en),
        .arm_ev       (arm_ev),
        .pad_ev       (pad_ev),
        .bad_ev       (bad_ev),
        .ctx_save     (ctx_save),
        .ctx_restore  (ctx_restore),
        .restore_pend (restore_pend),
        .pend_out     (pend_out),
        .cp_fault     (cp_fault)
    );
endmodule

// File: tb/sim_landing_pad_guard.sv
module sim_landing_pad_guard;
    localparam int PERIOD = 10;
    localparam int NV = 22;

    logic clk = 1'b0;
    logic rst_n, chk_en, ret_valid, ctx_save, ctx_restore, restore_pend;
    logic [1:0] ret_class;
    logic pend_out, cp_fault;
    int applied = 0, bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    landing_pad_guard u0 (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .ret_valid(ret_valid),
        .ret_class(ret_class), .ctx_save(ctx_save), .ctx_restore(ctx_restore),
        .restore_pend(restore_pend), .pend_out(pend_out), .cp_fault(cp_fault)
    );

    // {en, vld, cls[1:0], save, restore, rpend, exp_fault, exp_pend}
    localparam logic [8:0] VEC [NV] = '{
        9'b1_1_01_000_0_1,  // R2 jump arms
        9'b1_1_11_000_0_0,  // R4 land
        9'b1_1_10_000_0_1,  // R2 call arms
        9'b1_1_00_000_1_0,  // R5 violate
        9'b1_0_00_000_0_0,  // R5 one-cycle pulse
        9'b1_1_11_000_0_0,  // R6 marker in idle
        9'b1_1_00_000_0_0,  // R3 other never arms
        9'b1_1_01_000_0_1,  // R2
        9'b1_0_00_000_0_1,  // R7 hold
        9'b1_0_11_000_0_1,  // R7 class ignored without valid
        9'b1_1_00_100_0_0,  // R8 save wins over retire
        9'b1_0_00_011_0_1,  // R9 reload armed
        9'b1_1_00_000_1_0,  // R9 check reapplied
        9'b1_0_00_000_0_0,  // R5
        9'b1_0_00_010_0_0,  // R9 reload clear
        9'b1_1_01_000_0_1,  // R2
        9'b0_1_00_000_0_0,  // R10 disable clears, no fault
        9'b0_1_01_000_0_0,  // R10 no arm
        9'b1_1_01_010_0_0,  // R9 restore over retire
        9'b1_1_10_000_0_1,  // R2
        9'b1_1_01_000_1_0,  // R5 indirect after indirect
        9'b0_0_00_011_0_0   // R10 restore ignored
    };

    task automatic check(input logic act, input logic exp, input string req, input string what);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {chk_en, ret_valid, ret_class, ctx_save, ctx_restore, restore_pend} = v[8:2];
    endtask

    initial begin
        #(PERIOD*5000);
        if (!done) begin
            bad++;
            applied++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(9'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(pend_out, 1'b0, "R1", "pend after reset");
        check(cp_fault, 1'b0, "R1", "fault after reset");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(cp_fault, VEC[i][1], "vector", $sformatf("fault at %0d", i));
            check(pend_out, VEC[i][0], "vector", $sformatf("pend at %0d", i));
        end

        // R8 pend_out visible during the save cycle
        drive(9'b1_1_01_000_0_0);
        @(negedge clk);
        drive(9'b1_0_00_100_0_0);
        #1;
        check(pend_out, 1'b1, "R8", "pend exported in save cycle");
        @(negedge clk);
        check(pend_out, 1'b0, "R8", "disarmed after save");
        drive(9'b1_1_00_000_0_0);
        @(negedge clk);
        check(cp_fault, 1'b0, "R8", "handler instr unchecked");

        // R1 reset while waiting
        drive(9'b1_1_10_000_0_0);
        @(negedge clk);
        check(pend_out, 1'b1, "R1", "armed before reset");
        rst_n = 1'b0;
        drive(9'b1_1_00_000_0_0);
        @(negedge clk);
        check(pend_out, 1'b0, "R1", "pend in reset");
        check(cp_fault, 1'b0, "R1", "fault in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(cp_fault, 1'b0, "R1", "no fault after reset release");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule